// File: doc/BRIEF.md
# Range Register Update Sequencer

This block is the control engine that moves a processor core safely through a change of its memory-type range registers. One `start_i` pulse launches a fixed order of command steps. The steps go out to neighbouring logic (cache control, TLB, control-word and default-type register access) on a single command channel. Each step holds `cmd_valid_o` and waits until that logic returns `cmd_done_i`.

The sequence has three phases. The entry phase takes the update lock and turns caching off in no-fill mode. It flushes the caches, optionally clears the global-page enable, flushes the TLBs, saves the default-type register and then writes that register with ranges disabled and uncached as the default. The payload phase hands control to external logic through `payload_go_o`. That logic performs the range register writes. When it returns `payload_done_i`, it may also supply a new default type and new enable bits, which are folded into the saved image. The exit phase flushes the TLBs, writes the saved image back, turns caching on, restores the control word if global pages were in use, and drops the lock.

Top module: `range_update_seq`

## Requirements
- R1: While reset is asserted, and after it, until a start is seen, `busy_o`, `lock_req_o`, `cmd_valid_o` and `payload_go_o` are all low.
- R2: `start_i` raises `lock_req_o` and `busy_o`. No command is issued and no payload is started until `lock_gnt_i` is seen high.
- R3: Entry issues these op codes in order: 1 (cache off, no-fill), 2 (write back and invalidate), then 5 (TLB flush), 6 (default-type read), 7 (default-type write), 2. Non-write ops carry data 0.
- R4: If `gpe_en_i` was high at start, op 3 (control-word read) and then op 4 (control-word write) are inserted between the first op 2 and op 5. The op 4 data is the value read with bit 7 cleared. Otherwise neither op appears.
- R5: The entry op 7 writes the value returned by op 6 with bits 11:10 and 7:0 cleared.
- R6: After entry, `payload_go_o` stays high with no command valid until `payload_done_i` is seen.
- R7: Exit issues op 5, op 7 with the saved default image, op 8 (cache on) and, only if `gpe_en_i` was high at start, op 4 with the unmodified control word read on entry. No op 2 is issued on exit.
- R8: If `upd_valid_i` is high with `payload_done_i`, the exit image becomes (saved & ~0xCFF) | `upd_type_i` | (`upd_en_i` << 10). Otherwise it is the saved value unchanged.
- R9: A command's op and data stay stable while `cmd_valid_o` is high and `cmd_done_i` is low.
- R10: One cycle after the last exit command is accepted, `lock_req_o` and `busy_o` are low. A `start_i` pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a sequence when idle |
| gpe_en_i | input | 1 | Global pages in use; sampled at start |
| busy_o | output | 1 | Sequence in progress |
| lock_req_o | output | 1 | Update lock request |
| lock_gnt_i | input | 1 | Update lock grant |
| cmd_valid_o | output | 1 | Command step pending |
| cmd_op_o | output | 4 | Command op code |
| cmd_wdata_o | output | 32 | Write data for ops 4 and 7 |
| cmd_done_i | input | 1 | Command step completed |
| cmd_rdata_i | input | 32 | Read data returned with done for ops 3 and 6 |
| payload_go_o | output | 1 | Payload phase active |
| payload_done_i | input | 1 | Payload finished |
| upd_valid_i | input | 1 | New default type and enables present |
| upd_type_i | input | 8 | New default type |
| upd_en_i | input | 2 | New enable bits |

## Verification
The bench sweeps global-page use, handshake latency and three update cases (none, equal to saved, different). A design that dropped the global-page branch, or cleared the wrong bit, would show a missing op 3/4 or the wrong op 4 data. Sampling of the read data is tested by using different values for the control word and the default type; a bad sampler would write back a swapped or stale value. Merge errors would corrupt bits outside 11:10 and 7:0 or leave the new type out of the exit write. A stray exit flush, an early command before grant, or a restart caused by a start pulse during the payload would each show up as an out-of-order op or a busy block after exit.

// File: rtl/range_update_pkg.sv
package range_update_pkg;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_CACHE_OFF = 4'd1,
    OP_FLUSH_INV = 4'd2,
    OP_CTL_READ  = 4'd3,
    OP_CTL_WRITE = 4'd4,
    OP_TLB_FLUSH = 4'd5,
    OP_DEF_READ  = 4'd6,
    OP_DEF_WRITE = 4'd7,
    OP_CACHE_ON  = 4'd8
  } rus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOCK,
    ST_COFF,
    ST_FLUSH_A,
    ST_CTL_RD,
    ST_CTL_WR,
    ST_TLB_IN,
    ST_DEF_RD,
    ST_DEF_CLR,
    ST_FLUSH_B,
    ST_PAYLOAD,
    ST_TLB_OUT,
    ST_DEF_RST,
    ST_CON,
    ST_CTL_RST
  } rus_state_e;

endpackage

// File: rtl/rus_next_state.sv
module rus_next_state
  import range_update_pkg::*;
(
  input  rus_state_e state_q,
  input  logic       gpe_q,
  input  logic       start,
  input  logic       lock_gnt,
  input  logic       cmd_done,
  input  logic       payload_done,
  output rus_state_e state_n
);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:    if (start)        state_n = ST_LOCK;
      ST_LOCK:    if (lock_gnt)     state_n = ST_COFF;
      ST_COFF:    if (cmd_done)     state_n = ST_FLUSH_A;
      ST_FLUSH_A: if (cmd_done)     state_n = gpe_q ? ST_CTL_RD : ST_TLB_IN;
      ST_CTL_RD:  if (cmd_done)     state_n = ST_CTL_WR;
      ST_CTL_WR:  if (cmd_done)     state_n = ST_TLB_IN;
      ST_TLB_IN:  if (cmd_done)     state_n = ST_DEF_RD;
      ST_DEF_RD:  if (cmd_done)     state_n = ST_DEF_CLR;
      ST_DEF_CLR: if (cmd_done)     state_n = ST_FLUSH_B;
      ST_FLUSH_B: if (cmd_done)     state_n = ST_PAYLOAD;
      ST_PAYLOAD: if (payload_done) state_n = ST_TLB_OUT;
      ST_TLB_OUT: if (cmd_done)     state_n = ST_DEF_RST;
      ST_DEF_RST: if (cmd_done)     state_n = ST_CON;
      ST_CON:     if (cmd_done)     state_n = gpe_q ? ST_CTL_RST : ST_IDLE;
      ST_CTL_RST: if (cmd_done)     state_n = ST_IDLE;
      default:                      state_n = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rus_image_store.sv
module rus_image_store
  import range_update_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TYPE_W = 8,
  parameter int EN_W   = 2,
  parameter int EN_LSB = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rus_state_e        state_q,
  input  logic              cmd_done,
  input  logic [DATA_W-1:0] rdata,
  input  logic              payload_done,
  input  logic              upd_valid,
  input  logic [TYPE_W-1:0] upd_type,
  input  logic [EN_W-1:0]   upd_en,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] def_q
);

  localparam logic [DATA_W-1:0] TYPE_MASK = {{(DATA_W-TYPE_W){1'b0}}, {TYPE_W{1'b1}}};
  localparam logic [DATA_W-1:0] EN_MASK   = {{(DATA_W-EN_W){1'b0}}, {EN_W{1'b1}}} << EN_LSB;
  localparam logic [DATA_W-1:0] CLR_MASK  = TYPE_MASK | EN_MASK;

  logic              ctl_en, def_en, differs;
  logic [DATA_W-1:0] def_d, merged;

  assign differs = (def_q[TYPE_W-1:0] != upd_type) || (def_q[EN_LSB +: EN_W] != upd_en);
  assign merged  = (def_q & ~CLR_MASK) | DATA_W'(upd_type) | (DATA_W'(upd_en) << EN_LSB);

  always_comb begin
    ctl_en = (state_q == ST_CTL_RD) && cmd_done;
    def_en = 1'b0;
    def_d  = def_q;
    if ((state_q == ST_DEF_RD) && cmd_done) begin
      def_en = 1'b1;
      def_d  = rdata;
    end else if ((state_q == ST_PAYLOAD) && payload_done && upd_valid && differs) begin
      def_en = 1'b1;
      def_d  = merged;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      def_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= rdata;
      if (def_en) def_q <= def_d;
    end
  end

endmodule

// File: rtl/rus_cmd_mux.sv
module rus_cmd_mux
  import range_update_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TYPE_W  = 8,
  parameter int EN_W    = 2,
  parameter int EN_LSB  = 10,
  parameter int GPE_BIT = 7
) (
  input  rus_state_e        state_q,
  input  logic [DATA_W-1:0] ctl_q,
  input  logic [DATA_W-1:0] def_q,
  output logic              cmd_valid,
  output rus_op_e           cmd_op,
  output logic [DATA_W-1:0] cmd_wdata
);

  localparam logic [DATA_W-1:0] TYPE_MASK = {{(DATA_W-TYPE_W){1'b0}}, {TYPE_W{1'b1}}};
  localparam logic [DATA_W-1:0] EN_MASK   = {{(DATA_W-EN_W){1'b0}}, {EN_W{1'b1}}} << EN_LSB;
  localparam logic [DATA_W-1:0] CLR_MASK  = TYPE_MASK | EN_MASK;
  localparam logic [DATA_W-1:0] GPE_MASK  = {{(DATA_W-1){1'b0}}, 1'b1} << GPE_BIT;

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_NONE;
    cmd_wdata = '0;
    unique case (state_q)
      ST_COFF:                cmd_op = OP_CACHE_OFF;
      ST_FLUSH_A, ST_FLUSH_B: cmd_op = OP_FLUSH_INV;
      ST_CTL_RD:              cmd_op = OP_CTL_READ;
      ST_CTL_WR: begin
        cmd_op    = OP_CTL_WRITE;
        cmd_wdata = ctl_q & ~GPE_MASK;
      end
      ST_TLB_IN, ST_TLB_OUT:  cmd_op = OP_TLB_FLUSH;
      ST_DEF_RD:              cmd_op = OP_DEF_READ;
      ST_DEF_CLR: begin
        cmd_op    = OP_DEF_WRITE;
        cmd_wdata = def_q & ~CLR_MASK;
      end
      ST_DEF_RST: begin
        cmd_op    = OP_DEF_WRITE;
        cmd_wdata = def_q;
      end
      ST_CON:                 cmd_op = OP_CACHE_ON;
      ST_CTL_RST: begin
        cmd_op    = OP_CTL_WRITE;
        cmd_wdata = ctl_q;
      end
      default:                cmd_valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/range_update_seq.sv
module range_update_seq
  import range_update_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TYPE_W  = 8,
  parameter int EN_W    = 2,
  parameter int EN_LSB  = 10,
  parameter int GPE_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              gpe_en_i,
  output logic              busy_o,
  output logic              lock_req_o,
  input  logic              lock_gnt_i,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              cmd_done_i,
  input  logic [DATA_W-1:0] cmd_rdata_i,
  output logic              payload_go_o,
  input  logic              payload_done_i,
  input  logic              upd_valid_i,
  input  logic [TYPE_W-1:0] upd_type_i,
  input  logic [EN_W-1:0]   upd_en_i
);

  rus_state_e        state_q, state_n;
  logic              state_en, gpe_q, gpe_en;
  logic [DATA_W-1:0] ctl_q, def_q;
  rus_op_e           op;

  rus_next_state u_next (
    .state_q      (state_q),
    .gpe_q        (gpe_q),
    .start        (start_i),
    .lock_gnt     (lock_gnt_i),
    .cmd_done     (cmd_done_i),
    .payload_done (payload_done_i),
    .state_n      (state_n)
  );

  assign state_en = (state_n != state_q);
  assign gpe_en   = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gpe_q   <= 1'b0;
    end else begin
      if (state_en) state_q <= state_n;
      if (gpe_en)   gpe_q   <= gpe_en_i;
    end
  end

  rus_image_store #(
    .DATA_W (DATA_W), .TYPE_W (TYPE_W), .EN_W (EN_W), .EN_LSB (EN_LSB)
  ) u_img (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (state_q),
    .cmd_done     (cmd_done_i),
    .rdata        (cmd_rdata_i),
    .payload_done (payload_done_i),
    .upd_valid    (upd_valid_i),
    .upd_type     (upd_type_i),
    .upd_en       (upd_en_i),
    .ctl_q        (ctl_q),
    .def_q        (def_q)
  );

  rus_cmd_mux #(
    .DATA_W (DATA_W), .TYPE_W (TYPE_W), .EN_W (EN_W), .EN_LSB (EN_LSB), .GPE_BIT (GPE_BIT)
  ) u_mux (
    .state_q   (state_q),
    .ctl_q     (ctl_q),
    .def_q     (def_q),
    .cmd_valid (cmd_valid_o),
    .cmd_op    (op),
    .cmd_wdata (cmd_wdata_o)
  );

  assign cmd_op_o     = op;
  assign busy_o       = (state_q != ST_IDLE);
  assign lock_req_o   = (state_q != ST_IDLE);
  assign payload_go_o = (state_q == ST_PAYLOAD);

endmodule

// File: rtl/rus_checker.sv
module rus_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              lock_req_o,
  input logic              cmd_valid_o,
  input logic [3:0]        cmd_op_o,
  input logic [DATA_W-1:0] cmd_wdata_o,
  input logic              cmd_done_i,
  input logic              payload_go_o,
  input logic              payload_done_i
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!lock_req_o && !cmd_valid_o && !payload_go_o));

  a_r2_lock_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_req_o) |-> (!cmd_valid_o && !payload_go_o));

  a_r2_cmd_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o || payload_go_o) |-> lock_req_o);

  a_r6_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (payload_go_o && !payload_done_i) |=> (payload_go_o && !cmd_valid_o));

  a_r6_payload_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    payload_go_o |-> !cmd_valid_o);

  a_r9_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_done_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_wdata_o)));

endmodule

bind range_update_seq rus_checker #(.DATA_W(DATA_W)) i_rus_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_o         (busy_o),
  .lock_req_o     (lock_req_o),
  .cmd_valid_o    (cmd_valid_o),
  .cmd_op_o       (cmd_op_o),
  .cmd_wdata_o    (cmd_wdata_o),
  .cmd_done_i     (cmd_done_i),
  .payload_go_o   (payload_go_o),
  .payload_done_i (payload_done_i)
);

// File: tb/test_range_update_seq.sv
`timescale 1ns/1ps
module test_range_update_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, gpe_en_i, lock_gnt_i, cmd_done_i, payload_done_i;
  logic        upd_valid_i;
  logic [7:0]  upd_type_i;
  logic [1:0]  upd_en_i;
  logic [31:0] cmd_rdata_i;
  logic        busy_o, lock_req_o, cmd_valid_o, payload_go_o;
  logic [3:0]  cmd_op_o;
  logic [31:0] cmd_wdata_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  range_update_seq i_range_update_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gpe_en_i(gpe_en_i),
    .busy_o(busy_o), .lock_req_o(lock_req_o), .lock_gnt_i(lock_gnt_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_wdata_o(cmd_wdata_o),
    .cmd_done_i(cmd_done_i), .cmd_rdata_i(cmd_rdata_i),
    .payload_go_o(payload_go_o), .payload_done_i(payload_done_i),
    .upd_valid_i(upd_valid_i), .upd_type_i(upd_type_i), .upd_en_i(upd_en_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One command step: observe at a negedge, wait lat cycles, answer done.
  task automatic do_cmd(input logic [3:0] eop, input logic [31:0] edata,
                        input logic [31:0] rd, input int lat, input string req);
    @(negedge clk);
    cmd_done_i = 1'b0; payload_done_i = 1'b0; upd_valid_i = 1'b0;
    chk(cmd_valid_o && !payload_go_o, req, "cmd valid", {31'd0, cmd_valid_o}, 32'd1);
    chk(cmd_op_o == eop, req, "op", {28'd0, cmd_op_o}, {28'd0, eop});
    chk(cmd_wdata_o == edata, req, "data", cmd_wdata_o, edata);
    for (int i = 0; i < lat; i++) @(negedge clk);
    if (lat > 0)
      chk(cmd_valid_o && cmd_op_o == eop && cmd_wdata_o == edata, "R9", "held op",
          {28'd0, cmd_op_o}, {28'd0, eop});
    cmd_rdata_i = rd;
    cmd_done_i  = 1'b1;
  endtask

  task automatic run_seq(input bit gpe, input logic [31:0] ctl, input logic [31:0] dflt,
                         input int upd, input int lat, input bit poke);
    logic [31:0] img;
    logic [7:0]  t;
    logic [1:0]  e;
    t = (upd == 2) ? (dflt[7:0] ^ 8'h5A) : dflt[7:0];
    e = (upd == 2) ? ~dflt[11:10] : dflt[11:10];
    img = (upd != 0) ? ((dflt & ~32'h0000_0CFF) | {24'd0, t} | ({30'd0, e} << 10)) : dflt;

    @(negedge clk);
    start_i = 1'b1; gpe_en_i = gpe;
    @(negedge clk);
    start_i = 1'b0; gpe_en_i = ~gpe;
    chk(lock_req_o && busy_o, "R2", "lock request after start", {31'd0, lock_req_o}, 32'd1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!cmd_valid_o && !payload_go_o, "R2", "no cmd before grant", {31'd0, cmd_valid_o}, 32'd0);
    end
    lock_gnt_i = 1'b1;

    do_cmd(4'd1, 32'd0, 32'd0, lat, "R3");
    do_cmd(4'd2, 32'd0, 32'd0, lat, "R3");
    if (gpe) begin
      do_cmd(4'd3, 32'd0, ctl, lat, "R4");
      do_cmd(4'd4, ctl & ~32'h80, 32'hDEAD_BEEF, lat, "R4");
    end
    do_cmd(4'd5, 32'd0, 32'd0, lat, "R3");
    do_cmd(4'd6, 32'd0, dflt, lat, "R3");
    do_cmd(4'd7, dflt & ~32'h0000_0CFF, 32'h1234_5678, lat, "R5");
    do_cmd(4'd2, 32'd0, 32'd0, lat, "R3");

    // payload phase
    @(negedge clk);
    cmd_done_i = 1'b0;
    chk(payload_go_o && !cmd_valid_o, "R6", "payload active", {31'd0, payload_go_o}, 32'd1);
    for (int i = 0; i < lat + 1; i++) begin
      if (poke) start_i = 1'b1;
      @(negedge clk);
      chk(payload_go_o && !cmd_valid_o, "R6", "payload held", {31'd0, payload_go_o}, 32'd1);
    end
    start_i        = 1'b0;
    payload_done_i = 1'b1;
    upd_valid_i    = (upd != 0);
    upd_type_i     = t;
    upd_en_i       = e;

    do_cmd(4'd5, 32'd0, 32'd0, lat, "R7");
    do_cmd(4'd7, img, 32'd0, lat, "R8");
    do_cmd(4'd8, 32'd0, 32'd0, lat, "R7");
    if (gpe) do_cmd(4'd4, ctl, 32'd0, lat, "R7");

    @(negedge clk);
    cmd_done_i = 1'b0;
    chk(!busy_o && !lock_req_o && !cmd_valid_o, "R10", "released after exit",
        {30'd0, busy_o, lock_req_o}, 32'd0);
    lock_gnt_i = 1'b0;
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!busy_o && !cmd_valid_o, "R10", "start while busy ignored", {31'd0, busy_o}, 32'd0);
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; gpe_en_i = 1'b0; lock_gnt_i = 1'b0;
    cmd_done_i = 1'b0; payload_done_i = 1'b0; upd_valid_i = 1'b0;
    upd_type_i = '0; upd_en_i = '0; cmd_rdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !lock_req_o && !cmd_valid_o && !payload_go_o, "R1", "in reset",
        {28'd0, busy_o, lock_req_o, cmd_valid_o, payload_go_o}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !lock_req_o && !cmd_valid_o && !payload_go_o, "R1", "after reset",
        {28'd0, busy_o, lock_req_o, cmd_valid_o, payload_go_o}, 32'd0);

    for (int g = 0; g < 2; g++)
      for (int l = 0; l < 3; l++)
        for (int u = 0; u < 3; u++) begin
          int k;
          logic [31:0] c, d;
          k = g * 9 + l * 3 + u;
          c = 32'h8005_0033 ^ (k * 32'h0101_10C5);
          d = 32'h00A0_0000 ^ (k * 32'h0013_0D97);
          run_seq(g[0], c, d, u, l, (l != 0) && (u == 1));
        end

    finish_run();
  end

endmodule